// File: doc/BRIEF.md
# Transmit Checksum Offload Engine

This block sits in the transmit byte path of an Ethernet controller. It fills in the IPv4 header checksum and the TCP or UDP checksum of a frame, so that software does not have to compute them. Frames enter as a byte-wide valid/ready stream with start-of-frame and end-of-frame markers. A small set of control inputs travels with each frame and is sampled on its first byte. These inputs say whether to compute the IPv4 checksum, whether to compute the transport-layer checksum, whether the transport layer is TCP or UDP, and where the two headers begin.

The block works in store-and-forward mode. While a frame arrives, it writes the bytes into an internal buffer that infers as block RAM. It also accumulates both ones-complement sums as the bytes go by, and it reads the header length, total length and protocol fields on the fly. After the last byte it folds and inverts the sums in a single cycle. It then streams the frame out of the buffer and replaces the checksum bytes as they pass. The input stays stalled from the end of one frame until the last byte of that frame has left, so at most one frame is inside the block at any time.

Header positions are 8-bit byte counts. Byte 0 of the count is the first byte of the frame, which is the first destination-address byte. A VLAN tag that hardware inserts later never takes part in these counts.

Top module: `tx_csum_offload`

## Requirements
- R1: When the IP enable is 1, the 16-bit IPv4 header checksum is written big-endian at bytes ip_offset+10 and ip_offset+11. It is computed as the inverted ones-complement sum of the header's 16-bit big-endian words. The header length is 4 times the low nibble of the byte at ip_offset, so option words are included.
- R2: When the L4 enable is 1, the transport checksum is written big-endian into the transport header. It goes at l4_offset+16 when the TCP select bit is 1 (TCP) and at l4_offset+6 when it is 0 (UDP). The sum covers the following:
  - the source and destination addresses (IP header bytes 12 to 19);
  - the protocol byte (IP header byte 9) as a zero-extended word;
  - the transport length, which is the IP total length (IP header bytes 2 and 3) minus the header length;
  - the transport bytes up to that length, with an odd last byte padded with zero on the right.
  Frame bytes beyond the transport length are excluded.
- R3: For UDP, a computed checksum of 0x0000 is sent as 0xFFFF.
- R4: The two enables are independent. The bytes of a layer whose enable is 0 leave unchanged.
- R5: With both enables 0, the output frame is identical to the input byte for byte. It has the same length, with the start marker on the first byte and the end marker on the last byte only.
- R6: No output byte appears before the end byte of the frame has been accepted. in_ready is 0 whenever out_valid is 1, and it returns to 1 in the cycle after the last output byte is taken. After reset, out_valid is 0 and in_ready is 1.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sof and out_eof hold their values.
- R8: Offsets count from the first frame byte, which is index 0. The control inputs are used only on the start-of-frame beat, and their values on other beats have no effect.
- R9: Frames of up to DEPTH bytes (default 2048, which covers a 1518-byte frame) are processed whole.
- R10: The incoming contents of the checksum fields do not affect the result, because they count as zero in the sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| ctl_ip_en | input | 1 | Compute IPv4 header checksum (sampled with in_sof) |
| ctl_l4_en | input | 1 | Compute transport checksum (sampled with in_sof) |
| ctl_tcp | input | 1 | 1 = TCP, 0 = UDP (sampled with in_sof) |
| ctl_ip_off | input | 8 | IP header start, bytes from frame byte 0 |
| ctl_l4_off | input | 8 | Transport header start, bytes from frame byte 0 |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_sof | output | 1 | First output byte of frame |
| out_eof | output | 1 | Last output byte of frame |

## Verification
The in-line assertions check the following every cycle:
- the output hold under back-pressure;
- mutual exclusion of input acceptance and output presentation;
- the reopening of the input right after the last output byte;
- that no buffer write falls outside the store;
- that an armed UDP checksum is never zero.

Checksum values, byte positions, field ignoring, offset handling and control sampling only on the first beat depend on the frame contents. Only the bench's frames show these, because its behavioural model computes each expected byte. Those frames vary the header options, odd and padded transport lengths, a forced zero UDP sum, each enable combination, a shifted offset, random back-pressure and a maximum-size frame.

// File: rtl/tco_pkg.sv
package tco_pkg;

  typedef enum logic [1:0] {ST_FILL, ST_CALC, ST_DRAIN} tco_state_t;

  typedef struct packed {
    logic       ip_en;
    logic       l4_en;
    logic       tcp;
    logic [7:0] ip_off;
    logic [7:0] l4_off;
  } tco_ctl_t;

  // End-around carry twice: enough for any 32-bit accumulator value.
  function automatic logic [15:0] fold16(input logic [31:0] s);
    logic [16:0] a;
    logic [16:0] b;
    a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    b = {1'b0, a[15:0]} + {16'h0000, a[16]};
    return b[15:0];
  endfunction

endpackage

// File: rtl/tco_frame_store.sv
module tco_frame_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tco_sum_track.sv
module tco_sum_track #(
  parameter int IW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [IW-1:0]     idx,
  input  logic [7:0]        din,
  input  tco_pkg::tco_ctl_t ctl,
  output logic [31:0]       ip_sum,
  output logic [31:0]       l4_sum,
  output logic [7:0]        proto,
  output logic [15:0]       l4_len
);

  localparam logic [IW-1:0] K0  = IW'(0);
  localparam logic [IW-1:0] K2  = IW'(2);
  localparam logic [IW-1:0] K3  = IW'(3);
  localparam logic [IW-1:0] K9  = IW'(9);
  localparam logic [IW-1:0] K10 = IW'(10);
  localparam logic [IW-1:0] K11 = IW'(11);
  localparam logic [IW-1:0] K12 = IW'(12);
  localparam logic [IW-1:0] K19 = IW'(19);

  logic [3:0]    ihl_q;
  logic [15:0]   tl_q;
  logic [IW-1:0] ip_base, l4_base, rel_ip, rel_l4, hlen, cso;
  logic [3:0]    ihl_e;
  logic          at_ip, at_l4, in_ip, in_l4, ip_add, ph_add, l4_add;
  logic [15:0]   w_ip, w_l4;

  always_comb begin
    ip_base = {{(IW-8){1'b0}}, ctl.ip_off};
    l4_base = {{(IW-8){1'b0}}, ctl.l4_off};
    at_ip   = idx >= ip_base;
    at_l4   = idx >= l4_base;
    rel_ip  = idx - ip_base;
    rel_l4  = idx - l4_base;
    // The length nibble is usable in the same beat it arrives.
    ihl_e   = (at_ip && rel_ip == K0) ? din[3:0] : ihl_q;
    hlen    = {{(IW-6){1'b0}}, ihl_e, 2'b00};
    in_ip   = at_ip && (rel_ip < hlen);
    ip_add  = in_ip && (rel_ip != K10) && (rel_ip != K11);
    ph_add  = at_ip && (rel_ip >= K12) && (rel_ip <= K19);
    cso     = ctl.tcp ? IW'(16) : IW'(6);
    in_l4   = at_l4 && ({{(16-IW){1'b0}}, rel_l4} < l4_len);
    l4_add  = in_l4 && (rel_l4 != cso) && (rel_l4 != cso + IW'(1));
    w_ip    = rel_ip[0] ? {8'h00, din} : {din, 8'h00};
    w_l4    = rel_l4[0] ? {8'h00, din} : {din, 8'h00};
  end

  assign l4_len = tl_q - {10'b0, ihl_q, 2'b00};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ip_sum <= '0;
      l4_sum <= '0;
      ihl_q  <= '0;
      tl_q   <= '0;
      proto  <= '0;
    end else if (take) begin
      if (ip_add) ip_sum <= ip_sum + {16'h0000, w_ip};
      l4_sum <= l4_sum + (ph_add ? {16'h0000, w_ip} : 32'h0)
                       + (l4_add ? {16'h0000, w_l4} : 32'h0);
      if (at_ip && rel_ip == K0) ihl_q      <= din[3:0];
      if (at_ip && rel_ip == K2) tl_q[15:8] <= din;
      if (at_ip && rel_ip == K3) tl_q[7:0]  <= din;
      if (at_ip && rel_ip == K9) proto      <= din;
    end
  end

endmodule

// File: rtl/tx_csum_offload.sv
module tx_csum_offload #(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       ctl_ip_en,
  input  logic       ctl_l4_en,
  input  logic       ctl_tcp,
  input  logic [7:0] ctl_ip_off,
  input  logic [7:0] ctl_l4_off,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  import tco_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int IW = AW + 1;

  tco_state_t    state;
  tco_ctl_t      ctl_q, ctl_in, ctl_e;
  logic [IW-1:0] cnt, len, rd_idx, q_idx, ip_pos, l4_pos;
  logic          q_vld, take, load, issue;
  logic [15:0]   ip_c, l4_c, l4_raw, l4_len;
  logic [31:0]   ip_sum, l4_sum, l4_tot;
  logic [7:0]    proto, q_rd, pdata;

  assign in_ready = (state == ST_FILL);
  assign take     = in_valid && in_ready;
  assign ctl_in   = '{ip_en: ctl_ip_en, l4_en: ctl_l4_en, tcp: ctl_tcp,
                      ip_off: ctl_ip_off, l4_off: ctl_l4_off};
  assign ctl_e    = in_sof ? ctl_in : ctl_q;

  tco_frame_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(take), .waddr(cnt[AW-1:0]), .wdata(in_data),
    .re(issue), .raddr(rd_idx[AW-1:0]), .rdata(q_rd)
  );

  tco_sum_track #(.IW(IW)) u_sum (
    .clk(clk), .rst(rst), .clr(state == ST_CALC), .take(take), .idx(cnt),
    .din(in_data), .ctl(ctl_e), .ip_sum(ip_sum), .l4_sum(l4_sum),
    .proto(proto), .l4_len(l4_len)
  );

  assign l4_tot = l4_sum + {24'h0, proto} + {16'h0, l4_len};
  assign l4_raw = ~fold16(l4_tot);

  // Drain pipeline: one read in flight, one byte in the output register.
  assign load  = (state == ST_DRAIN) && q_vld && (!out_valid || out_ready);
  assign issue = (state == ST_DRAIN) && (rd_idx < len) && (!q_vld || load);

  assign ip_pos = {{(IW-8){1'b0}}, ctl_q.ip_off} + IW'(10);
  assign l4_pos = {{(IW-8){1'b0}}, ctl_q.l4_off} + (ctl_q.tcp ? IW'(16) : IW'(6));

  always_comb begin
    pdata = q_rd;
    if (ctl_q.ip_en && q_idx == ip_pos)          pdata = ip_c[15:8];
    if (ctl_q.ip_en && q_idx == ip_pos + IW'(1)) pdata = ip_c[7:0];
    if (ctl_q.l4_en && q_idx == l4_pos)          pdata = l4_c[15:8];
    if (ctl_q.l4_en && q_idx == l4_pos + IW'(1)) pdata = l4_c[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FILL;
      ctl_q     <= '0;
      cnt       <= '0;
      len       <= '0;
      rd_idx    <= '0;
      q_idx     <= '0;
      q_vld     <= 1'b0;
      ip_c      <= '0;
      l4_c      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      case (state)
        ST_FILL: if (take) begin
          cnt <= cnt + IW'(1);
          if (in_sof) ctl_q <= ctl_in;
          if (in_eof) begin
            len   <= cnt + IW'(1);
            cnt   <= '0;
            state <= ST_CALC;
          end
        end
        ST_CALC: begin
          ip_c   <= ~fold16(ip_sum);
          l4_c   <= (!ctl_q.tcp && l4_raw == 16'h0000) ? 16'hFFFF : l4_raw;
          rd_idx <= '0;
          q_vld  <= 1'b0;
          state  <= ST_DRAIN;
        end
        default: begin
          if (issue) begin
            rd_idx <= rd_idx + IW'(1);
            q_idx  <= rd_idx;
            q_vld  <= 1'b1;
          end else if (load) begin
            q_vld <= 1'b0;
          end
          if (out_valid && out_ready && out_eof) state <= ST_FILL;
        end
      endcase
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= pdata;
        out_sof   <= (q_idx == '0);
        out_eof   <= (q_idx == len - IW'(1));
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: a stalled output byte holds
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

  // R6: input and output never both open
  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R6: input reopens right after the last byte leaves
  p_reopen_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_eof |=> in_ready && !out_valid);

  // R9: writes stay inside the store
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    take |-> cnt < IW'(DEPTH));

  // R3: an armed UDP checksum is never zero
  p_udp_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) && ctl_q.l4_en && !ctl_q.tcp |-> l4_c != 16'h0000);

endmodule

// File: tb/tx_csum_offload_test.sv
module tx_csum_offload_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic       ctl_ip_en = 1'b0, ctl_l4_en = 1'b0, ctl_tcp = 1'b0;
  logic [7:0] ctl_ip_off = '0, ctl_l4_off = '0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_sof, out_eof;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  tx_csum_offload uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .ctl_ip_en(ctl_ip_en), .ctl_l4_en(ctl_l4_en), .ctl_tcp(ctl_tcp),
    .ctl_ip_off(ctl_ip_off), .ctl_l4_off(ctl_l4_off),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  int checks = 0, fails = 0;
  logic [7:0] frm[$];
  logic [7:0] exp_q[$];
  string cur_req = "R5";
  bit bp = 0, first = 1, hold_chk = 0;
  logic [7:0] held_d;
  logic held_s, held_e;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int fold(input longint s);
    while ((s >> 16) != 0) s = (s & 64'hFFFF) + (s >> 16);
    return int'(s);
  endfunction

  function automatic int wd(input int p);
    return int'(frm[p]) * 256 + int'(frm[p+1]);
  endfunction

  function automatic int ip_calc(input int ipo);
    int hl = (int'(frm[ipo]) & 15) * 4;
    longint s = 0;
    for (int k = 0; k < hl; k += 2) if (k != 10) s += wd(ipo + k);
    return (~fold(s)) & 'hFFFF;
  endfunction

  function automatic int l4_calc(input bit tcp, input int ipo, input int l4o);
    int hl = (int'(frm[ipo]) & 15) * 4;
    int tl = wd(ipo + 2);
    int n = tl - hl;
    int cso = tcp ? 16 : 6;
    longint s = 0;
    for (int k = 12; k < 20; k += 2) s += wd(ipo + k);
    s += int'(frm[ipo+9]) + n;
    for (int k = 0; k < n; k += 2)
      if (k != cso) s += int'(frm[l4o+k]) * 256 + ((k + 1 < n) ? int'(frm[l4o+k+1]) : 0);
    return (~fold(s)) & 'hFFFF;
  endfunction

  task automatic make_expect(input bit ip_en, input bit l4_en, input bit tcp, input int ipo, input int l4o);
    int c;
    exp_q = frm;
    if (ip_en) begin
      c = ip_calc(ipo);
      exp_q[ipo+10] = 8'(c >> 8);
      exp_q[ipo+11] = 8'(c);
    end
    if (l4_en) begin
      c = l4_calc(tcp, ipo, l4o);
      if (!tcp && c == 0) c = 'hFFFF;
      exp_q[l4o + (tcp ? 16 : 6)]     = 8'(c >> 8);
      exp_q[l4o + (tcp ? 16 : 6) + 1] = 8'(c);
    end
  endtask

  task automatic build(input int ipo, input int ihl, input bit tcp, input int paylen, input int padlen);
    int hl = ihl * 4;
    int tl = hl + (tcp ? 20 : 8) + paylen;
    frm.delete();
    for (int i = 0; i < ipo; i++) frm.push_back(8'($urandom));
    frm.push_back(8'(8'h40 | ihl)); frm.push_back(8'h00);
    frm.push_back(8'(tl >> 8));     frm.push_back(8'(tl));
    frm.push_back(8'($urandom));    frm.push_back(8'($urandom));
    frm.push_back(8'h40);           frm.push_back(8'h00);
    frm.push_back(8'h40);           frm.push_back(tcp ? 8'd6 : 8'd17);
    frm.push_back(8'hAB);           frm.push_back(8'hCD); // stale field, R10
    for (int i = 0; i < 8 + (ihl - 5) * 4; i++) frm.push_back(8'($urandom));
    for (int i = 0; i < (tcp ? 20 : 8) + paylen; i++) frm.push_back(8'($urandom));
    for (int i = 0; i < padlen; i++) frm.push_back(8'($urandom));
  endtask

  task automatic send(input bit ip_en, input bit l4_en, input bit tcp, input int ipo, input int l4o);
    int i = 0;
    while (i < frm.size()) begin
      @(negedge clk);
      chk(!out_valid, "R6 no output during fill", int'(out_valid), 0);
      if ($urandom % 5 == 0) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = frm[i];
        in_sof   = (i == 0);
        in_eof   = (i == frm.size() - 1);
        if (i == 0) begin
          ctl_ip_en = ip_en; ctl_l4_en = l4_en; ctl_tcp = tcp;
          ctl_ip_off = 8'(ipo); ctl_l4_off = 8'(l4o);
        end else begin
          // R8: control on later beats must be ignored
          {ctl_ip_en, ctl_l4_en, ctl_tcp} = 3'($urandom);
          ctl_ip_off = 8'($urandom); ctl_l4_off = 8'($urandom);
        end
        if (in_ready) i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic run(input string req, input bit ip_en, input bit l4_en, input bit tcp,
                     input int ipo, input int ihl, input int paylen, input int padlen, input bit zero_udp);
    int l4o = ipo + ihl * 4;
    int c;
    build(ipo, ihl, tcp, paylen, padlen);
    if (zero_udp) begin
      // R3: tune a payload word so the UDP sum comes out as zero
      frm[l4o+8] = 8'h00; frm[l4o+9] = 8'h00;
      c = l4_calc(1'b0, ipo, l4o);
      frm[l4o+8] = 8'(c >> 8); frm[l4o+9] = 8'(c);
    end
    make_expect(ip_en, l4_en, tcp, ipo, l4o);
    cur_req = req;
    send(ip_en, l4_en, tcp, ipo, l4o);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(in_ready, {req, " R6 input reopens"}, int'(in_ready), 1);
  endtask

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_chk)
        chk(out_valid && out_data == held_d && out_sof == held_s && out_eof == held_e,
            "R7 hold under stall", int'(out_data), int'(held_d));
      out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      hold_chk = out_valid && !out_ready;
      held_d = out_data; held_s = out_sof; held_e = out_eof;
      if (out_valid) chk(!in_ready, "R6 input stalled while draining", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_req, " unexpected byte"}, int'(out_data), 0);
        end else begin
          chk(out_data == exp_q[0], cur_req, int'(out_data), int'(exp_q[0]));
          chk(out_sof == first && out_eof == (exp_q.size() == 1),
              {cur_req, " R5 framing"}, {out_sof, out_eof}, {first, exp_q.size() == 1});
          void'(exp_q.pop_front());
          first = (exp_q.size() == 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R6 reset out_valid", int'(out_valid), 0);
    chk(in_ready, "R6 reset in_ready", int'(in_ready), 1);
    run("R1 R2 TCP both layers", 1, 1, 1, 14, 5, 40, 0, 0);
    run("R2 UDP odd length", 1, 1, 0, 14, 5, 33, 0, 0);
    run("R3 UDP zero sent as FFFF", 1, 1, 0, 14, 5, 20, 0, 1);
    run("R4 R1 IP only with options", 1, 0, 1, 14, 7, 30, 0, 0);
    run("R4 R2 L4 only with padding", 0, 1, 0, 14, 5, 25, 6, 0);
    run("R5 neither enable", 0, 0, 1, 14, 5, 10, 4, 0);
    bp = 1;
    run("R8 R7 offset 18 backpressure", 1, 1, 1, 18, 6, 50, 3, 0);
    run("R10 stale fields ignored", 1, 1, 0, 22, 5, 12, 0, 0);
    run("R9 maximum frame", 1, 1, 1, 14, 5, 1464, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule